// File: doc/BRIEF.md
# Logic Tile with Cascaded Wide-Function Multiplexers

This block models one logic tile of a programmable fabric. It holds eight 4-input lookup tables. Each table reads its 16-bit configuration word and drives a combinational output and a flip-flop. A fixed tree of 2:1 multiplexers joins the table outputs into functions of five, six, seven and eight inputs. The last stage takes one of its two inputs from the tile to the right. Two tiles chained this way can therefore produce any function of eight inputs.

The flip-flops are grouped in pairs. Each pair shares one clock line, one set/reset line and one clock-enable line. Each flip-flop has its own 5-bit mode field, which selects:
- the active clock edge,
- whether the clock enable is used,
- the set/reset behaviour: none, synchronous clear, synchronous set, asynchronous clear or asynchronous preset.

Configuration words are plain input ports. How they are loaded is outside this block.

Top module: `wide_lut_tile`

## Requirements
- R1: `lut_f[i]` equals bit `{in_d[i],in_c[i],in_b[i],in_a[i]}` of `lut_init[16i+15:16i]`, with `in_a` as the least significant index bit.
- R2: For k = 0..3, `mux_of[2k]` is `lut_f[2k+1]` when `mux_sel[2k]` is 1 and `lut_f[2k]` when it is 0.
- R3: For k = 0..1, `mux_of[4k+1]` is `mux_of[4k]` when `mux_sel[4k+1]` is 1 and `mux_of[4k+2]` when it is 0.
- R4: `mux_of[3]` is `mux_of[1]` when `mux_sel[3]` is 1, else `mux_of[5]`. `mux_of[7]` is `mux_of[3]` when `mux_sel[7]` is 1, else `of_from_right`.
- R5: When the right neighbour's `mux_of[3]` feeds `of_from_right`, the two tiles together reproduce an arbitrary 8-input function on `mux_of[7]` for all 256 input combinations.
- R6: Flip-flop i is clocked by `clk_pair[i/2]` and loads `lut_f[i]`. Bit 1 of its mode field `ff_mode[5i+4:5i]` selects the edge: 0 for rising, 1 for falling.
- R7: When bit 0 of the mode field is 1, flip-flop i loads only on edges where `ce_pair[i/2]` is 1, and holds its value otherwise.
- R8: Mode bits [4:2] = 1 (synchronous clear) or 2 (synchronous set) force 0 or 1 on an active edge while `lsr_pair[i/2]` is 1. This takes priority over the clock enable.
- R9: Mode bits [4:2] = 3 (asynchronous clear) or 4 (asynchronous preset) force 0 or 1 as soon as `lsr_pair[i/2]` is 1, without waiting for a clock edge.
- R10: With mode bits [4:2] = 0, `lsr_pair` has no effect on the flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pair | input | 4 | Clock of each flip-flop pair |
| lsr_pair | input | 4 | Set/reset line of each pair |
| ce_pair | input | 4 | Clock enable of each pair |
| in_a | input | 8 | Index bit 0 of each table |
| in_b | input | 8 | Index bit 1 of each table |
| in_c | input | 8 | Index bit 2 of each table |
| in_d | input | 8 | Index bit 3 of each table |
| mux_sel | input | 8 | Select of each wide-function multiplexer |
| of_from_right | input | 1 | Seven-input result of the tile to the right |
| lut_init | input | 128 | Configuration words, 16 bits per table |
| ff_mode | input | 40 | Mode fields, 5 bits per flip-flop |
| lut_f | output | 8 | Combinational table outputs |
| ff_q | output | 8 | Flip-flop outputs |
| mux_of | output | 8 | Multiplexer tree outputs |

## Verification
Table and multiplexer results are combinational, so they are due in the same cycle as the input change. The bench drives inputs 3 ns after the rising edge and compares 8 ns after it.

Rising-edge flip-flops show their new value right after the edge. Falling-edge flip-flops show it half a period later, and the mid-cycle sample falls after both.

Asynchronous clear and preset are checked 1 ns after the set/reset line rises, well before any clock edge. This shows that they do not wait for one.

// File: rtl/tile_pkg.sv
package tile_pkg;

  // table geometry
  localparam int LUT_K      = 4;
  localparam int LUT_INIT_W = 1 << LUT_K;

  // set/reset behaviour of a tile flip-flop
  typedef enum logic [2:0] {
    SR_OFF       = 3'd0,
    SR_SYNC_CLR  = 3'd1,
    SR_SYNC_SET  = 3'd2,
    SR_ASYNC_CLR = 3'd3,
    SR_ASYNC_SET = 3'd4
  } sr_mode_e;

  // per flip-flop mode field: [4:2] set/reset, [1] falling edge, [0] enable used
  typedef struct packed {
    sr_mode_e sr;
    logic     fall_edge;
    logic     ce_used;
  } ff_cfg_t;

  localparam int FF_CFG_W = $bits(ff_cfg_t);

  // 2:1 selection used by every wide-function stage
  function automatic logic pick2(input logic sel, input logic in0, input logic in1);
    return sel ? in1 : in0;
  endfunction

endpackage

// File: rtl/tile_lut.sv
module tile_lut #(
  parameter int K = tile_pkg::LUT_K
) (
  input  logic [(1<<K)-1:0] init,
  input  logic [K-1:0]      idx,
  output logic              f
);

  assign f = init[idx];

endmodule

// File: rtl/tile_ff.sv
module tile_ff
  import tile_pkg::*;
(
  input  logic    clk,
  input  logic    lsr,
  input  logic    ce,
  input  ff_cfg_t cfg,
  input  logic    d,
  output logic    q
);

  logic ck;
  logic is_async;
  logic arst;
  logic arst_val;
  logic sync_hit;
  logic sync_val;

  // programmable clock inversion selects the active edge
  assign ck       = clk ^ cfg.fall_edge;
  assign is_async = (cfg.sr == SR_ASYNC_CLR) || (cfg.sr == SR_ASYNC_SET);
  assign arst     = lsr & is_async;
  assign arst_val = (cfg.sr == SR_ASYNC_SET);
  assign sync_hit = lsr & ((cfg.sr == SR_SYNC_CLR) || (cfg.sr == SR_SYNC_SET));
  assign sync_val = (cfg.sr == SR_SYNC_SET);

  always_ff @(posedge ck or posedge arst) begin
    if (arst) begin
      q <= arst_val;
    end else if (sync_hit) begin
      q <= sync_val;
    end else if (!cfg.ce_used || ce) begin
      q <= d;
    end
  end

  // R6: an enabled edge with no forcing captures the table output
  p_load_r6: assert property (@(posedge ck) disable iff (arst)
    (!sync_hit && (!cfg.ce_used || ce)) |=> (q == $past(d)));

  // R7: a disabled edge keeps the stored value
  p_hold_r7: assert property (@(posedge ck) disable iff (arst)
    (cfg.ce_used && !ce && !sync_hit) |=> $stable(q));

  // R8: synchronous forcing wins over the enable
  p_sync_force_r8: assert property (@(posedge ck) disable iff (arst)
    sync_hit |=> (q == (cfg.sr == SR_SYNC_SET)));

endmodule

// File: rtl/tile_mux_tree.sv
module tile_mux_tree
  import tile_pkg::*;
#(
  parameter int N_LUT = 8
) (
  input  logic [N_LUT-1:0] f,
  input  logic [N_LUT-1:0] sel,
  input  logic             of_far,
  output logic [N_LUT-1:0] of
);

  localparam int N_S1 = N_LUT / 2;
  localparam int N_S2 = N_LUT / 4;

  logic [N_S1-1:0] s1;
  logic [N_S2-1:0] s2;
  logic            s3;
  logic            s4;

  // five-input stage: neighbouring table pairs
  for (genvar g = 0; g < N_S1; g++) begin : g_s1
    assign s1[g]    = pick2(sel[2*g], f[2*g], f[2*g+1]);
    assign of[2*g]  = s1[g];
  end

  // six-input stage: the upper five-input result is the zero leg
  for (genvar g = 0; g < N_S2; g++) begin : g_s2
    assign s2[g]      = pick2(sel[4*g+1], s1[2*g+1], s1[2*g]);
    assign of[4*g+1]  = s2[g];
  end

  // seven-input stage inside the tile
  assign s3    = pick2(sel[3], s2[1], s2[0]);
  assign of[3] = s3;

  // eight-input stage reaches into the tile on the right
  assign s4    = pick2(sel[7], of_far, s3);
  assign of[7] = s4;

endmodule

// File: rtl/wide_lut_tile.sv
module wide_lut_tile
  import tile_pkg::*;
#(
  parameter int N_LUT = 8
) (
  input  logic [N_LUT/2-1:0]          clk_pair,
  input  logic [N_LUT/2-1:0]          lsr_pair,
  input  logic [N_LUT/2-1:0]          ce_pair,
  input  logic [N_LUT-1:0]            in_a,
  input  logic [N_LUT-1:0]            in_b,
  input  logic [N_LUT-1:0]            in_c,
  input  logic [N_LUT-1:0]            in_d,
  input  logic [N_LUT-1:0]            mux_sel,
  input  logic                        of_from_right,
  input  logic [N_LUT*LUT_INIT_W-1:0] lut_init,
  input  logic [N_LUT*FF_CFG_W-1:0]   ff_mode,
  output logic [N_LUT-1:0]            lut_f,
  output logic [N_LUT-1:0]            ff_q,
  output logic [N_LUT-1:0]            mux_of
);

  localparam int N_PAIR = N_LUT / 2;

  for (genvar i = 0; i < N_LUT; i++) begin : g_cell
    tile_lut #(.K(LUT_K)) u_lut (
      .init (lut_init[i*LUT_INIT_W +: LUT_INIT_W]),
      .idx  ({in_d[i], in_c[i], in_b[i], in_a[i]}),
      .f    (lut_f[i])
    );

    tile_ff u_ff (
      .clk (clk_pair[i/2]),
      .lsr (lsr_pair[i/2]),
      .ce  (ce_pair[i/2]),
      .cfg (ff_cfg_t'(ff_mode[i*FF_CFG_W +: FF_CFG_W])),
      .d   (lut_f[i]),
      .q   (ff_q[i])
    );
  end

  tile_mux_tree #(.N_LUT(N_LUT)) u_tree (
    .f      (lut_f),
    .sel    (mux_sel),
    .of_far (of_from_right),
    .of     (mux_of)
  );

  // R1: an all-ones word makes the table output 1 for every index
  p_ones_word_r1: assert property (@(posedge clk_pair[0]) disable iff (lsr_pair[0])
    (&lut_init[LUT_INIT_W-1:0]) |-> lut_f[0]);

  // R4: all selects of the path set routes table 1 through four stages
  p_path_t1_r4: assert property (@(posedge clk_pair[N_PAIR-1]) disable iff (lsr_pair[N_PAIR-1])
    (mux_sel[7] && mux_sel[3] && mux_sel[1] && mux_sel[0]) |-> (mux_of[7] == lut_f[1]));

  // R3: the zero leg of the seven-input stage reaches table 4
  p_path_t4_r3: assert property (@(posedge clk_pair[N_PAIR-1]) disable iff (lsr_pair[N_PAIR-1])
    (mux_sel[7] && !mux_sel[3] && mux_sel[5] && !mux_sel[4]) |-> (mux_of[7] == lut_f[4]));

endmodule

// File: tb/sim_wide_lut_tile.sv
module sim_wide_lut_tile;

  localparam int N  = 8;
  localparam int NP = 4;
  localparam int IW = 16;
  localparam int FW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NP-1:0]   lsr, ce;
  logic [N-1:0]    ia, ib, ic, id, sel;
  logic [N*IW-1:0] init0, init1;
  logic [N*FW-1:0] ffm;
  logic [N-1:0]    f0, q0, of0, f1, q1, of1;

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 0;
  bit  mon  = 0;

  wide_lut_tile u0 (
    .clk_pair({NP{clk}}), .lsr_pair(lsr), .ce_pair(ce),
    .in_a(ia), .in_b(ib), .in_c(ic), .in_d(id), .mux_sel(sel),
    .of_from_right(of1[3]), .lut_init(init0), .ff_mode(ffm),
    .lut_f(f0), .ff_q(q0), .mux_of(of0)
  );

  wide_lut_tile u_nb (
    .clk_pair('0), .lsr_pair('0), .ce_pair('0),
    .in_a(ia), .in_b(ib), .in_c(ic), .in_d(id), .mux_sel(sel),
    .of_from_right(1'b0), .lut_init(init1), .ff_mode('0),
    .lut_f(f1), .ff_q(q1), .mux_of(of1)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [7:0] m_f(input logic [N*IW-1:0] w);
    logic [7:0] r;
    for (int i = 0; i < N; i++) r[i] = w[i*IW + int'({id[i], ic[i], ib[i], ia[i]})];
    return r;
  endfunction

  function automatic logic [7:0] m_of(input logic [7:0] f, input logic far);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) r[2*k] = sel[2*k] ? f[2*k+1] : f[2*k];
    for (int k = 0; k < 2; k++) r[4*k+1] = sel[4*k+1] ? r[4*k] : r[4*k+2];
    r[3] = sel[3] ? r[1] : r[5];
    r[7] = sel[7] ? r[3] : far;
    return r;
  endfunction

  function automatic logic [7:0] m_tile_of();
    logic [7:0] nb;
    nb = m_of(m_f(init1), 1'b0);
    return m_of(m_f(init0), nb[3]);
  endfunction

  function automatic logic g8(input logic [7:0] x);
    return (^(x & 8'h5B)) ^ (x[7:4] > x[3:0]);
  endfunction

  logic [N-1:0] mq  = '0;
  logic [N-1:0] mok = '0;

  function automatic int srm(input int i);
    return int'(ffm[i*FW+2 +: 3]);
  endfunction

  task automatic step(input int i);
    logic [7:0] fv;
    int p, m;
    fv = m_f(init0);
    p  = i / 2;
    m  = srm(i);
    if (lsr[p] && (m == 3 || m == 4)) begin
      mq[i] = (m == 4); mok[i] = 1'b1;
    end else if (lsr[p] && (m == 1 || m == 2)) begin
      mq[i] = (m == 2); mok[i] = 1'b1;
    end else if (!ffm[i*FW] || ce[p]) begin
      mq[i] = fv[i]; mok[i] = 1'b1;
    end
  endtask

  always @(posedge clk) for (int i = 0; i < N; i++) if (!ffm[i*FW+1]) step(i);
  always @(negedge clk) for (int i = 0; i < N; i++) if (ffm[i*FW+1]) step(i);
  always @(lsr) for (int i = 0; i < N; i++)
    if (lsr[i/2] && (srm(i) == 3 || srm(i) == 4)) begin
      mq[i] = (srm(i) == 4); mok[i] = 1'b1;
    end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  string qtag [N] = '{"R9 async clr", "R9 async clr", "R7 enable", "R10 no sr",
                      "R6 falling edge", "R8 sync clr", "R8 sync set", "R9 async preset"};

  always @(posedge clk) if (mon) begin
    logic [7:0] eo;
    #8;
    eo = m_tile_of();
    chk("R1 lut_f", f0, m_f(init0));
    chk("R2 five-input stage", of0 & 8'h55, eo & 8'h55);
    chk("R3 six-input stage", of0 & 8'h22, eo & 8'h22);
    chk("R4 upper stages", of0 & 8'h88, eo & 8'h88);
    for (int i = 0; i < N; i++)
      if (mok[i]) chk(qtag[i], {7'd0, q0[i]}, {7'd0, mq[i]});
  end

  task automatic cyc();
    @(posedge clk);
    #3;
  endtask

  task automatic rnd_in();
    ia = N'($urandom); ib = N'($urandom); ic = N'($urandom);
    id = N'($urandom); sel = N'($urandom);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    lsr = '1; ce = '0;
    ia = '0; ib = '0; ic = '0; id = '0; sel = '0;
    for (int i = 0; i < N; i++) begin
      init0[i*IW +: IW] = 16'h6996 ^ IW'(i * 16'h1357);
      init1[i*IW +: IW] = 16'hA5C3 ^ IW'(i * 16'h0F11);
    end
    // flops 0,1 async clr; 2 enable; 3 plain; 4 falling sync clr; 5 sync clr; 6 sync set; 7 async preset
    ffm = {5'h10, 5'h08, 5'h04, 5'h06, 5'h00, 5'h01, 5'h0C, 5'h0C};
    mon = 1'b1;
    repeat (3) cyc();
    // reset state of all forced flops
    chk("R8 R9 reset state", q0 & 8'hF3, 8'hC0);

    lsr = '0; ce = '1;
    repeat (40) begin cyc(); rnd_in(); end

    // R7: toggle the enable of pair 1
    for (int k = 0; k < 16; k++) begin
      cyc(); rnd_in(); ce[1] = k[1] ^ k[0];
    end
    ce = '1;

    // R10: set/reset on pair 1 is ignored
    cyc(); lsr[1] = 1'b1;
    repeat (4) begin cyc(); rnd_in(); end
    lsr[1] = 1'b0;
    // R8: synchronous clear on pair 2, with enable low
    cyc(); lsr[2] = 1'b1; ce[2] = 1'b0;
    repeat (3) begin cyc(); rnd_in(); end
    lsr[2] = 1'b0; ce[2] = 1'b1;

    // R9: asynchronous clear acts without an edge
    init0[2*IW-1:0] = '1;
    cyc(); cyc();
    lsr[0] = 1'b1;
    #1 chk("R9 async clr immediate", {6'd0, q0[1:0]}, 8'h00);
    cyc(); cyc(); lsr[0] = 1'b0;

    // R9/R8: preset on flop 7 immediate, set on flop 6 at the edge
    init0[8*IW-1 -: IW] = '0;
    init0[7*IW-1 -: IW] = '0;
    cyc(); cyc();
    lsr[3] = 1'b1;
    #1 chk("R9 async preset immediate", {7'd0, q0[7]}, 8'h01);
    cyc();
    chk("R8 sync set at edge", {7'd0, q0[6]}, 8'h01);
    cyc(); lsr[3] = 1'b0;

    // R5: two tiles build one 8-input function
    init0 = '0; init1 = '0;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] xv;
      int L;
      xv = 8'(x);
      L  = xv[6] ? (xv[5] ? 0 : 2) : (xv[5] ? 4 : 6);
      L  = L + int'(xv[4]);
      if (xv[7]) init0[L*IW + int'(xv[3:0])] = g8(xv);
      else       init1[L*IW + int'(xv[3:0])] = g8(xv);
    end
    for (int x = 0; x < 256; x++) begin
      logic [7:0] xv;
      cyc();
      xv  = 8'(x);
      ia  = {N{xv[0]}}; ib = {N{xv[1]}}; ic = {N{xv[2]}}; id = {N{xv[3]}};
      sel = {xv[7], xv[4], xv[5], xv[4], xv[6], xv[4], xv[5], xv[4]};
      #3 chk("R5 eight-input function", {7'd0, of0[7]}, {7'd0, g8(xv)});
    end

    cyc();
    mon  = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule